// File: doc/BRIEF.md
# Conversion Result Queue with Byte-Wide Host Reads

This block buffers the results that a converter engine produces until a host collects them over a register bus. Each pushed result is a 13-bit two's-complement value together with the 3-bit address of the instruction that produced it. The block packs these into a 16-bit word. The upper three bits hold either the instruction address or copies of the sign, as a configuration input selects. When the engine runs at reduced resolution, the four lowest bits are replaced by a fixed filler pattern.

The queue holds 32 words. When a result arrives while the queue is full, the oldest word is discarded so that the newest result is kept. The host sees a live fill count. A level interrupt rises once the count reaches a programmable threshold, which lets the host stop the engine before the last slot is overrun. The interrupt does not hold off the producer in any way.

A host on a 16-bit bus pops one whole word per read. A host on an 8-bit bus reads the low byte first, with the address bit at 0, and then the high byte, with the address bit at 1. Only the high-byte read pops the word, so reading the high byte first loses that word's low byte.

Top module: `result_fifo`

## Requirements
- R1: After reset the queue is empty, `fill_count` is 0, `empty` is 1, `full` is 0 and `rd_data` is 0.
- R2: Stored bits 12:0 are the pushed result. Bits 15:13 are the instruction address when `cfg_tag_mode` is 1, and three copies of result bit 12 when it is 0.
- R3: When `push_lowres` is 1, stored bits 3:0 are forced to 4'b1110 and bits 12:4 come from the result.
- R4: Words are read back in push order. `fill_count` rises by one for each accepted push and falls by one for each pop, and never exceeds 32.
- R5: A push into a full queue with no pop in the same cycle discards the oldest word. The count stays at 32.
- R6: With `bus8`=0, a read loads the head word into `rd_data` one clock later and pops it, whatever the value of `rd_a0`.
- R7: With `bus8`=1 and `rd_a0`=0, a read loads {8'h00, head[7:0]} into `rd_data` and does not pop.
- R8: With `bus8`=1 and `rd_a0`=1, a read loads {8'h00, head[15:8]} into `rd_data` and pops the word.
- R9: `irq` equals `irq_en` AND (`fill_count` >= `irq_thr`). With `irq_thr`=31 it first rises when the 31st word is stored.
- R10: A read of an empty queue leaves `rd_data` and the read position unchanged. A push in the same cycle is still stored.
- R11: A push and a pop in the same cycle, when the queue is neither empty nor full, leave `fill_count` unchanged.
- R12: Pushes are accepted while `irq` is high. The count keeps rising above the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | A result is offered this cycle |
| push_result | input | 13 | Signed conversion result |
| push_instr | input | 3 | Address of the producing instruction |
| push_lowres | input | 1 | Result is at reduced resolution |
| cfg_tag_mode | input | 1 | 1: top bits carry the instruction address; 0: sign extension |
| rd_en | input | 1 | Host read strobe |
| rd_a0 | input | 1 | Byte select in 8-bit mode (0 low, 1 high) |
| bus8 | input | 1 | 1: 8-bit host bus; 0: 16-bit |
| irq_en | input | 1 | Fill interrupt enable |
| irq_thr | input | 5 | Fill threshold |
| rd_data | output | 16 | Registered read data |
| fill_count | output | 6 | Number of stored words |
| empty | output | 1 | Queue holds no words |
| full | output | 1 | Queue holds 32 words |
| irq | output | 1 | Fill interrupt level |

## Verification
The bench builds the block with its default depth of 32. At this depth a few hundred cycles of push-heavy random traffic drive the queue into the full state over and over, which exercises the drop-oldest path. It also takes the count past every threshold value, including the 31 case. Read-heavy phases empty the queue again, so reads of an empty queue also occur. Bus width, byte select, tag mode and resolution change at random, so every read kind lands on words of every format.

// File: rtl/result_fifo_pkg.sv
package result_fifo_pkg;
  localparam int RES_W  = 13;
  localparam int TAG_W  = 3;
  localparam int WORD_W = RES_W + TAG_W;
  localparam int BYTE_W = 8;
  localparam int FILL_W = 4;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_WORD,
    RD_LOW,
    RD_HIGH
  } rd_kind_e;
endpackage

// File: rtl/rf_word_fmt.sv
module rf_word_fmt
  import result_fifo_pkg::*;
(
  input  logic [RES_W-1:0] result,
  input  logic [TAG_W-1:0] instr,
  input  logic             lowres,
  input  logic             tag_mode,
  output word_t            word
);
  localparam logic [FILL_W-1:0] FILL_PAT = 4'b1110;

  always_comb begin
    if (lowres) begin
      word[RES_W-1:0] = {result[RES_W-1:FILL_W], FILL_PAT};
    end else begin
      word[RES_W-1:0] = result;
    end
    if (tag_mode) begin
      word[WORD_W-1:RES_W] = instr;
    end else begin
      word[WORD_W-1:RES_W] = {TAG_W{result[RES_W-1]}};
    end
  end
endmodule

// File: rtl/rf_store.sv
module rf_store
  import result_fifo_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  word_t                        wdata,
  input  logic                         pop,
  output word_t                        head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty,
  output logic                         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  word_t            mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, rd_ptr_n;
  logic [PTR_W-1:0] wr_ptr, wr_ptr_n;
  logic [CNT_W-1:0] cnt_n;
  logic             pop_ok, drop, rd_adv;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty  = (count == '0);
  assign full   = (count == CNT_MAX);
  assign pop_ok = pop && !empty;
  assign drop   = push && full && !pop_ok;
  assign rd_adv = pop_ok || drop;
  assign head   = mem[rd_ptr];

  always_comb begin
    rd_ptr_n = rd_adv ? step(rd_ptr) : rd_ptr;
    wr_ptr_n = push ? step(wr_ptr) : wr_ptr;
    unique case ({push, pop_ok})
      2'b10:   cnt_n = full ? count : count + 1'b1;
      2'b01:   cnt_n = count - 1'b1;
      default: cnt_n = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= rd_ptr_n;
      wr_ptr <= wr_ptr_n;
      count  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_ptr] <= wdata;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_MAX); // R4
  AST_DROP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !pop |=> full); // R5
  AST_PUSH_POP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop && !empty && !full |=> $stable(count)); // R11
endmodule

// File: rtl/rf_host_port.sv
module rf_host_port
  import result_fifo_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_en,
  input  logic  rd_a0,
  input  logic  bus8,
  input  word_t head,
  input  logic  empty,
  output word_t rd_data,
  output logic  pop
);
  rd_kind_e kind;
  word_t    data_n;
  logic     load;

  always_comb begin
    if (!rd_en) begin
      kind = RD_NONE;
    end else if (!bus8) begin
      kind = RD_WORD;
    end else if (rd_a0) begin
      kind = RD_HIGH;
    end else begin
      kind = RD_LOW;
    end
  end

  always_comb begin
    unique case (kind)
      RD_LOW:  data_n = {{(WORD_W-BYTE_W){1'b0}}, head[BYTE_W-1:0]};
      RD_HIGH: data_n = {{(WORD_W-BYTE_W){1'b0}}, head[WORD_W-1:BYTE_W]};
      default: data_n = head;
    endcase
  end

  assign load = (kind != RD_NONE) && !empty;
  assign pop  = !empty && ((kind == RD_WORD) || (kind == RD_HIGH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (load) begin
      rd_data <= data_n;
    end
  end

  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && empty |=> $stable(rd_data)); // R10
endmodule

// File: rtl/result_fifo.sv
module result_fifo
  import result_fifo_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push_valid,
  input  logic [12:0]                 push_result,
  input  logic [2:0]                  push_instr,
  input  logic                        push_lowres,
  input  logic                        cfg_tag_mode,
  input  logic                        rd_en,
  input  logic                        rd_a0,
  input  logic                        bus8,
  input  logic                        irq_en,
  input  logic [$clog2(DEPTH)-1:0]    irq_thr,
  output logic [15:0]                 rd_data,
  output logic [$clog2(DEPTH+1)-1:0]  fill_count,
  output logic                        empty,
  output logic                        full,
  output logic                        irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  word_t wword;
  word_t head;
  logic  pop;

  rf_word_fmt u_fmt (
    .result   (push_result),
    .instr    (push_instr),
    .lowres   (push_lowres),
    .tag_mode (cfg_tag_mode),
    .word     (wword)
  );

  rf_store #(.DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_valid),
    .wdata (wword),
    .pop   (pop),
    .head  (head),
    .count (fill_count),
    .empty (empty),
    .full  (full)
  );

  rf_host_port u_host (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_a0   (rd_a0),
    .bus8    (bus8),
    .head    (head),
    .empty   (empty),
    .rd_data (rd_data),
    .pop     (pop)
  );

  assign irq = irq_en && (fill_count >= CNT_W'(irq_thr));

  AST_LOW_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && bus8 && !rd_a0 && !push_valid |=> $stable(fill_count)); // R7
  AST_PUSH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !rd_en && !full |=> fill_count == $past(fill_count) + 1'b1); // R12
endmodule

// File: tb/sim_result_fifo.sv
`timescale 1ns/1ps
module sim_result_fifo;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        push_valid, push_lowres, cfg_tag_mode;
  logic [12:0] push_result;
  logic [2:0]  push_instr;
  logic        rd_en, rd_a0, bus8, irq_en;
  logic [4:0]  irq_thr;
  logic [15:0] rd_data;
  logic [5:0]  fill_count;
  logic        empty, full, irq;

  int checks = 0;
  int fails  = 0;
  logic [15:0] q[$];
  logic [15:0] exp_rd;

  always #2.5 clk = ~clk;

  result_fifo #(.DEPTH(DEPTH)) u0 (
    .clk, .rst_n, .push_valid, .push_result, .push_instr, .push_lowres,
    .cfg_tag_mode, .rd_en, .rd_a0, .bus8, .irq_en, .irq_thr,
    .rd_data, .fill_count, .empty, .full, .irq
  );

  function automatic logic [15:0] fmt(input logic [12:0] r, input logic [2:0] ins,
                                      input logic lr, input logic tg);
    logic [15:0] w;
    w[12:0]  = lr ? {r[12:4], 4'b1110} : r;
    w[15:13] = tg ? ins : {3{r[12]}};
    return w;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic p, input logic [12:0] r, input logic [2:0] ins,
                     input logic lr, input logic tg, input logic rd,
                     input logic a0, input logic b8);
    string tag;
    logic  popd;
    push_valid = p; push_result = r; push_instr = ins; push_lowres = lr;
    cfg_tag_mode = tg; rd_en = rd; rd_a0 = a0; bus8 = b8;
    @(posedge clk);
    #1;
    tag = "R10";
    popd = 1'b0;
    if (rd && q.size() > 0) begin
      if (!b8) begin exp_rd = q[0]; tag = "R6"; popd = 1'b1; end
      else if (a0) begin exp_rd = {8'h00, q[0][15:8]}; tag = "R8"; popd = 1'b1; end
      else begin exp_rd = {8'h00, q[0][7:0]}; tag = "R7"; end
    end
    if (popd) void'(q.pop_front());
    if (p) begin
      if (q.size() == DEPTH) void'(q.pop_front());
      q.push_back(fmt(r, ins, lr, tg));
    end
    if (rd) check(rd_data == exp_rd, tag, rd_data, exp_rd);
    check(fill_count == q.size(), "R4 count", fill_count, q.size());
    check(irq == (irq_en && fill_count >= irq_thr), "R9 irq", irq,
          irq_en && fill_count >= irq_thr);
  endtask

  task automatic idle();
    cyc(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    exp_rd = '0;
    rst_n = 1'b0; push_valid = 0; push_result = 0; push_instr = 0; push_lowres = 0;
    cfg_tag_mode = 0; rd_en = 0; rd_a0 = 0; bus8 = 0; irq_en = 0; irq_thr = 5'd1;
    #12;
    rst_n = 1'b1;
    #1;
    check(empty && !full && fill_count == 0 && rd_data == 0 && !irq, "R1 reset",
          {empty, full, fill_count}, 32'h80);

    // R2: sign extension, then tag mode
    cyc(1, 13'h1234, 3'd5, 0, 0, 0, 0, 0);
    cyc(1, 13'h0234, 3'd5, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    check(rd_data == 16'hF234, "R2 sign ext", rd_data, 16'hF234);
    cyc(0, 0, 0, 0, 0, 1, 1, 0);
    check(rd_data == 16'hA234, "R2 tag R6 a0 ignored", rd_data, 16'hA234);
    // R3: reduced resolution filler
    cyc(1, 13'h0AB5, 3'd2, 1, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    check(rd_data == 16'h4ABE, "R3 filler", rd_data, 16'h4ABE);

    // R7/R8: byte reads, high-first loses low byte
    cyc(1, 13'h1C3D, 3'd6, 0, 1, 0, 0, 0);
    cyc(1, 13'h0155, 3'd1, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 1);
    check(rd_data == 16'h003D && fill_count == 2, "R7 low no pop", rd_data, 16'h003D);
    cyc(0, 0, 0, 0, 0, 1, 1, 1);
    check(rd_data == 16'h00DC, "R8 high pop", rd_data, 16'h00DC);
    cyc(0, 0, 0, 0, 0, 1, 1, 1);
    check(rd_data == 16'h0021 && fill_count == 0, "R8 high first", rd_data, 16'h0021);

    // R10: empty read with concurrent push
    cyc(1, 13'h0777, 3'd3, 0, 1, 1, 0, 0);
    check(rd_data == 16'h0021 && fill_count == 1, "R10 hold", rd_data, 16'h0021);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    check(rd_data == 16'h6777, "R10 push kept", rd_data, 16'h6777);

    // R9/R12/R5: threshold 31, fill past it, overflow drops oldest
    irq_en = 1; irq_thr = 5'd31;
    for (int i = 0; i < 30; i++) cyc(1, 13'(i), 3'd0, 0, 0, 0, 0, 0);
    check(!irq, "R9 below thr", irq, 0);
    cyc(1, 13'd30, 3'd0, 0, 0, 0, 0, 0);
    check(irq, "R9 at 31", irq, 1);
    cyc(1, 13'd31, 3'd0, 0, 0, 0, 0, 0);
    check(full && fill_count == 32, "R12 push past irq", fill_count, 32);
    cyc(1, 13'd32, 3'd0, 0, 0, 0, 0, 0);
    check(fill_count == 32, "R5 count stays", fill_count, 32);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    check(rd_data == 16'd1, "R5 oldest dropped", rd_data, 16'd1);
    // R11: push and pop together
    cyc(1, 13'd99, 3'd0, 0, 0, 1, 0, 0);
    check(fill_count == 31, "R11 count kept", fill_count, 31);
    irq_en = 0;
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    check(!irq, "R9 disabled", irq, 0);

    // random traffic in phases
    for (int ph = 0; ph < 16; ph++) begin
      int pp = (ph % 2 == 0) ? 75 : 30;
      irq_en  = $urandom_range(0, 1);
      irq_thr = 5'($urandom);
      for (int i = 0; i < 200; i++) begin
        cyc(($urandom % 100) < pp, 13'($urandom), 3'($urandom), 1'($urandom),
            1'($urandom), ($urandom % 100) < 50, 1'($urandom), 1'($urandom));
      end
    end
    idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule